// File: doc/BRIEF.md
# Packed Pixel Unpacker

This block sits behind a memory read engine. It takes a stream of 32-bit words holding packed pixels and turns it into a stream of pixels, one per handshake. Each pixel carries three 8-bit colour channels and an 8-bit alpha. For RGB layouts, channel 0 is red, channel 1 is green and channel 2 is blue. For interleaved 4:2:2 luma/chroma layouts, channel 0 is Y, channel 1 is U and channel 2 is V. Memory bytes are taken little-endian: byte 0 is `in_data[7:0]`.

A 4-bit format code selects the packing. Two swap bits pick among the memory orderings that share one code. A 2-bit layout field must say "interleaved" (value 2); value 1 (semi-planar) and every other value are rejected. Incoming bytes are queued in a small byte buffer, so pixels whose size does not divide the word size can straddle word boundaries. The configuration is held constant between resets. To change it, reset the block.

Top module: `pix_unpack`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1 and, for a supported configuration, `err` is 0.
- R2: Code 6: each word is one pixel, with memory bytes in the order B, G, R, A; alpha is taken from byte 3.
- R3: Code 7: each word is one pixel, with memory bytes in the order A, B, G, R.
- R4: Code 5: each pixel is three bytes B, G, R, and pixels straddle words, so every 3 words give 4 pixels in byte-stream order.
- R5: Code 4: each word holds two pixels, the low halfword first; within a halfword, R is bits 15:11, G is bits 10:5 and B is bits 4:0. Each channel is widened to 8 bits by copying its top bits into the freed low bits.
- R6: Code 1 with the luma/chroma swap bit set: bytes Y0, U, Y1, V. This gives pixel (Y0,U,V) then pixel (Y1,U,V).
- R7: Code 1 with the luma/chroma swap bit clear: bytes U, Y0, V, Y1. The two pixels come out in the same order as in R6.
- R8: The red/blue swap bit exchanges channels 0 and 2 for RGB codes, and channels 1 and 2 (U and V) for code 1.
- R9: Codes below 6 output an alpha of 0xFF.
- R10: Codes 0, 2, 3 and 8 to 15, or a layout other than 2, set `err`. While `err` is set, `out_valid` stays 0 and `in_ready` stays 1, and accepted words are dropped.
- R11: While `out_valid` is high and `out_ready` is low, the pixel is held unchanged. Every pixel is delivered exactly once.
- R12: `in_ready` falls when more than 4 bytes are buffered. With `out_ready` held low, this happens after two words have been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_fmt | input | 4 | Format code |
| cfg_rbswap | input | 1 | Red/blue or U/V exchange |
| cfg_ycswap | input | 1 | Luma-first ordering for 4:2:2 |
| cfg_layout | input | 2 | Read layout (2 = interleaved) |
| in_valid | input | 1 | Word valid |
| in_ready | output | 1 | Word accepted when both high |
| in_data | input | 32 | Packed word |
| out_valid | output | 1 | Pixel valid |
| out_ready | input | 1 | Pixel taken when both high |
| px_c0 | output | 8 | R or Y |
| px_c1 | output | 8 | G or U |
| px_c2 | output | 8 | B or V |
| px_a | output | 8 | Alpha |
| err | output | 1 | Unsupported configuration |

## Verification
A word accepted on a clock edge can raise `out_valid` with its first pixel right after that edge, and a popped pixel is replaced by the next one from the same edge. `in_ready`, `out_valid` and `err` are combinational from the buffer level and the configuration, with no added delay. The bench drives inputs shortly after the falling edge and samples the outputs one time unit later. It treats a handshake as occurring at the next rising edge, and it feeds accepted words into its own byte-queue model only after comparing the pixel leaving in that same cycle. This ordering matches the one-edge latency described above.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;

  typedef struct packed {
    logic [7:0] a;
    logic [7:0] c2;
    logic [7:0] c1;
    logic [7:0] c0;
  } pix_t;

  localparam logic [3:0] FMT_YUV420 = 4'd0;
  localparam logic [3:0] FMT_YUV422 = 4'd1;
  localparam logic [3:0] FMT_RGB565 = 4'd4;
  localparam logic [3:0] FMT_RGB888 = 4'd5;
  localparam logic [3:0] FMT_RGBA   = 4'd6;
  localparam logic [3:0] FMT_ARGB   = 4'd7;
  localparam logic [1:0] LAYOUT_INTERLEAVED = 2'd2;

  // widen a 5-bit channel to 8 bits by repeating its top bits
  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  // widen a 6-bit channel to 8 bits by repeating its top bits
  function automatic logic [7:0] widen6(input logic [5:0] v);
    return {v, v[5:4]};
  endfunction

  // decode one pixel from the four oldest buffered bytes
  function automatic pix_t decode_pixel(input logic [3:0] fmt, input logic rb,
                                        input logic yc, input logic [31:0] w,
                                        input logic ph);
    pix_t p;
    logic [7:0] r, g, b, y0, y1, u, v;
    r = 8'h00; g = 8'h00; b = 8'h00;
    p.a = 8'hFF;
    case (fmt)
      FMT_RGB565: begin
        r = widen5(w[15:11]);
        g = widen6(w[10:5]);
        b = widen5(w[4:0]);
      end
      FMT_RGB888: begin
        b = w[7:0]; g = w[15:8]; r = w[23:16];
      end
      FMT_RGBA: begin
        b = w[7:0]; g = w[15:8]; r = w[23:16]; p.a = w[31:24];
      end
      FMT_ARGB: begin
        p.a = w[7:0]; b = w[15:8]; g = w[23:16]; r = w[31:24];
      end
      default: ;
    endcase
    if (fmt == FMT_YUV422) begin
      if (yc) begin
        y0 = w[7:0];  u = w[15:8];  y1 = w[23:16]; v = w[31:24];
      end else begin
        u = w[7:0];   y0 = w[15:8]; v = w[23:16];  y1 = w[31:24];
      end
      p.c0 = ph ? y1 : y0;
      p.c1 = rb ? v : u;
      p.c2 = rb ? u : v;
    end else begin
      p.c0 = rb ? b : r;
      p.c1 = g;
      p.c2 = rb ? r : b;
    end
    return p;
  endfunction

endpackage

// File: rtl/pix_unpack_cfg.sv
module pix_unpack_cfg (
  input  logic [3:0] fmt,
  input  logic [1:0] layout,
  output logic       bad,
  output logic [2:0] grp_bytes,
  output logic       two_px
);
  import pix_unpack_pkg::*;

  always_comb begin
    bad       = 1'b0;
    grp_bytes = 3'd4;
    two_px    = 1'b0;
    case (fmt)
      FMT_YUV422: two_px = 1'b1;
      FMT_RGB565: grp_bytes = 3'd2;
      FMT_RGB888: grp_bytes = 3'd3;
      FMT_RGBA, FMT_ARGB: grp_bytes = 3'd4;
      default: bad = 1'b1;
    endcase
    if (layout != LAYOUT_INTERLEAVED) bad = 1'b1;
  end
endmodule

// File: rtl/pix_unpack_buf.sv
module pix_unpack_buf #(
  parameter int WORD_BYTES = 4,
  parameter int BUF_WORDS  = 2,
  localparam int BUF_BYTES = WORD_BYTES * BUF_WORDS,
  localparam int BUF_BITS  = 8 * BUF_BYTES,
  localparam int CW        = $clog2(BUF_BYTES + 1),
  localparam int PW        = $clog2(WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    push,
  input  logic [8*WORD_BYTES-1:0] word,
  input  logic [PW-1:0]           pop_n,
  output logic [8*WORD_BYTES-1:0] window,
  output logic [CW-1:0]           held
);
  logic [BUF_BITS-1:0] store;
  logic [BUF_BITS-1:0] shifted, inserted;
  logic [CW-1:0]       held_after_pop;

  always_comb begin
    shifted        = store >> {pop_n, 3'b000};
    held_after_pop = held - CW'(pop_n);
    inserted       = BUF_BITS'(word) << {held_after_pop, 3'b000};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store <= '0;
      held  <= '0;
    end else if (push) begin
      store <= shifted | inserted;
      held  <= held_after_pop + CW'(WORD_BYTES);
    end else begin
      store <= shifted;
      held  <= held_after_pop;
    end
  end

  assign window = store[8*WORD_BYTES-1:0];
endmodule

// File: rtl/pix_unpack_map.sv
module pix_unpack_map (
  input  logic [3:0]  fmt,
  input  logic        rb,
  input  logic        yc,
  input  logic [31:0] win,
  input  logic        ph,
  output logic [7:0]  c0,
  output logic [7:0]  c1,
  output logic [7:0]  c2,
  output logic [7:0]  a
);
  import pix_unpack_pkg::*;
  pix_t p;
  always_comb p = decode_pixel(fmt, rb, yc, win, ph);
  assign c0 = p.c0;
  assign c1 = p.c1;
  assign c2 = p.c2;
  assign a  = p.a;
endmodule

// File: rtl/pix_unpack.sv
module pix_unpack #(
  parameter int BUF_WORDS = 2,
  localparam int WORD_BYTES = 4,
  localparam int BUF_BYTES  = WORD_BYTES * BUF_WORDS,
  localparam int CW         = $clog2(BUF_BYTES + 1),
  localparam int PW         = $clog2(WORD_BYTES + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  cfg_fmt,
  input  logic        cfg_rbswap,
  input  logic        cfg_ycswap,
  input  logic [1:0]  cfg_layout,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  px_c0,
  output logic [7:0]  px_c1,
  output logic [7:0]  px_c2,
  output logic [7:0]  px_a,
  output logic        err
);
  logic          cfg_err;
  logic [2:0]    grp_bytes;
  logic          two_px;
  logic [CW-1:0] bytes_held;
  logic [31:0]   window;
  logic [PW-1:0] pop_n;
  logic          phase;
  logic          word_push, pix_xfer, grp_done;
  logic [7:0]    held_bytes_w;

  pix_unpack_cfg u_cfg (
    .fmt(cfg_fmt), .layout(cfg_layout), .bad(cfg_err),
    .grp_bytes(grp_bytes), .two_px(two_px)
  );

  assign err       = cfg_err;
  assign in_ready  = cfg_err || (bytes_held <= CW'(BUF_BYTES - WORD_BYTES));
  assign out_valid = !cfg_err && (bytes_held >= CW'(grp_bytes));
  assign word_push = in_valid && in_ready && !cfg_err;
  assign pix_xfer  = out_valid && out_ready;
  assign grp_done  = pix_xfer && (!two_px || phase);
  assign pop_n     = grp_done ? PW'(grp_bytes) : '0;
  assign held_bytes_w = 8'(bytes_held);

  always_ff @(posedge clk) begin
    if (!rst_n)                  phase <= 1'b0;
    else if (pix_xfer && two_px) phase <= ~phase;
  end

  pix_unpack_buf #(.WORD_BYTES(WORD_BYTES), .BUF_WORDS(BUF_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_n), .push(word_push), .word(in_data),
    .pop_n(pop_n), .window(window), .held(bytes_held)
  );

  pix_unpack_map u_map (
    .fmt(cfg_fmt), .rb(cfg_rbswap), .yc(cfg_ycswap), .win(window), .ph(phase),
    .c0(px_c0), .c1(px_c1), .c2(px_c2), .a(px_a)
  );
endmodule

// File: rtl/pix_unpack_chk.sv
module pix_unpack_chk #(
  parameter int CAP = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  cfg_fmt,
  input logic        err,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] pix,
  input logic [7:0]  held
);
  a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!out_valid && in_ready));

  a_r11_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(pix)));

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    held <= 8'(CAP));

  a_r12_ready_level: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready) |-> (held > 8'(CAP - 4)));

  a_r9_opaque: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_fmt < 4'd6) |-> (pix[31:24] == 8'hFF));
endmodule

bind pix_unpack pix_unpack_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .err(err),
  .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready),
  .pix({px_a, px_c2, px_c1, px_c0}), .held(held_bytes_w)
);

// File: tb/sim_pix_unpack.sv
`timescale 1ns/1ps
module sim_pix_unpack;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] cfg_fmt = 4'd6;
  logic cfg_rbswap = 1'b0, cfg_ycswap = 1'b0;
  logic [1:0] cfg_layout = 2'd2;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, err;
  logic [7:0] px_c0, px_c1, px_c2, px_a;

  int total = 0, bad = 0;
  logic [7:0]  bq[$];
  logic [31:0] eq[$];

  always #5 clk = ~clk;

  pix_unpack u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] up5(logic [4:0] x);
    return 8'((int'(x) * 255 + 15) / 31) ;
  endfunction

  // bench model: consume bytes from the queue into expected pixels
  task automatic model_drain();
    int need;
    logic [7:0] r, g, b, a, y0, y1, u, v;
    logic [15:0] h;
    need = (cfg_fmt == 4'd4) ? 2 : (cfg_fmt == 4'd5) ? 3 : 4;
    while (bq.size() >= need) begin
      a = 8'hFF;
      r = 0; g = 0; b = 0;
      if (cfg_fmt == 4'd1) begin
        y0 = cfg_ycswap ? bq[0] : bq[1];
        y1 = cfg_ycswap ? bq[2] : bq[3];
        u  = cfg_ycswap ? bq[1] : bq[0];
        v  = cfg_ycswap ? bq[3] : bq[2];
        if (cfg_rbswap) begin r = u; u = v; v = r; end
        eq.push_back({a, v, u, y0});
        eq.push_back({a, v, u, y1});
      end else begin
        if (cfg_fmt == 4'd4) begin
          h = {bq[1], bq[0]};
          r = {h[15:11], 3'b0} | 8'(h[15:11] >> 2);
          g = {h[10:5], 2'b0}  | 8'(h[10:5] >> 4);
          b = {h[4:0], 3'b0}   | 8'(h[4:0] >> 2);
        end else if (cfg_fmt == 4'd7) begin
          a = bq[0]; b = bq[1]; g = bq[2]; r = bq[3];
        end else begin
          b = bq[0]; g = bq[1]; r = bq[2];
          if (cfg_fmt == 4'd6) a = bq[3];
        end
        if (cfg_rbswap) eq.push_back({a, r, g, b});
        else            eq.push_back({a, b, g, r});
      end
      for (int k = 0; k < need; k++) void'(bq.pop_front());
    end
  endtask

  task automatic do_reset(logic [3:0] f, logic rb, logic yc, logic [1:0] lay);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    cfg_fmt = f; cfg_rbswap = rb; cfg_ycswap = yc; cfg_layout = lay;
    bq.delete(); eq.delete();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(string tag, logic [3:0] f, logic rb, logic yc,
                     int nwords, int rdy_pct, logic [31:0] fixed[$]);
    int sent = 0;
    int guard = 0;
    do_reset(f, rb, yc, 2'd2);
    #1;
    chk({tag, " R1 reset out_valid"}, 32'(out_valid), 0);
    chk({tag, " R1 reset in_ready"}, 32'(in_ready), 1);
    chk({tag, " R1 reset err"}, 32'(err), 0);
    while ((sent < nwords || eq.size() > 0) && guard < 20000) begin
      guard++;
      @(negedge clk);
      in_valid  = (sent < nwords) && ($urandom % 4 != 0);
      in_data   = (sent < fixed.size()) ? fixed[sent] : $urandom;
      out_ready = (sent >= nwords) || (($urandom % 100) < rdy_pct);
      #1;
      if (out_valid && out_ready) begin
        if (eq.size() == 0) chk({tag, " R11 extra pixel"}, 1, 0);
        else begin
          chk({tag, " pixel"}, {px_a, px_c2, px_c1, px_c0}, eq[0]);
          if (cfg_fmt < 4'd6) chk({tag, " R9 alpha"}, 32'(px_a), 32'hFF);
          void'(eq.pop_front());
        end
      end
      if (in_valid && in_ready) begin
        for (int k = 0; k < 4; k++) bq.push_back(in_data[8*k +: 8]);
        sent++;
        model_drain();
      end
    end
    chk({tag, " R11 all pixels delivered"}, 32'(eq.size()), 0);
  endtask

  initial begin
    logic [31:0] none[$];
    logic [31:0] d888[$];
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] none[$];
    logic [31:0] d888[$];
    void'($urandom(32'd20251));
    d888 = '{32'h44332211, 32'h88776655, 32'hCCBBAA99};
    run("R2", 4'd6, 0, 0, 40, 70, none);
    run("R3", 4'd7, 0, 0, 40, 50, none);
    run("R4 directed", 4'd5, 0, 0, 3, 100, d888);
    run("R4", 4'd5, 0, 0, 60, 60, none);
    run("R5", 4'd4, 0, 0, 40, 70, none);
    run("R6", 4'd1, 0, 1, 40, 70, none);
    run("R7", 4'd1, 0, 0, 40, 40, none);
    run("R8 rgb", 4'd5, 1, 0, 30, 80, none);
    run("R8 yuv", 4'd1, 1, 1, 30, 80, none);
    run("R8 565", 4'd4, 1, 0, 30, 30, none);
    run("R11 stall", 4'd6, 0, 0, 30, 15, none);

    // R10: unsupported codes and layout
    foreach (none[i]) ;
    for (int c = 0; c < 4; c++) begin
      logic [3:0] f;
      logic [1:0] lay;
      f   = (c == 0) ? 4'd0 : (c == 1) ? 4'd2 : (c == 2) ? 4'd9 : 4'd6;
      lay = (c == 3) ? 2'd1 : 2'd2;
      do_reset(f, 0, 0, lay);
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        in_valid = 1'b1; in_data = $urandom; out_ready = 1'b1;
        #1;
        chk("R10 err", 32'(err), 1);
        chk("R10 out_valid", 32'(out_valid), 0);
        chk("R10 in_ready", 32'(in_ready), 1);
      end
    end

    // R12: stall output, two words fill the buffer
    do_reset(4'd6, 0, 0, 2'd2);
    @(negedge clk);
    in_valid = 1'b1; in_data = 32'hA1B2C3D4; out_ready = 1'b0;
    #1 chk("R12 ready word1", 32'(in_ready), 1);
    @(negedge clk);
    in_data = 32'h01020304;
    #1 chk("R12 ready word2", 32'(in_ready), 1);
    chk("R2 first pixel held", {px_a, px_c2, px_c1, px_c0}, 32'hA1D4C3B2);
    @(negedge clk);
    in_valid = 1'b0;
    #1 chk("R12 ready low when full", 32'(in_ready), 0);
    chk("R11 pixel still held", {px_a, px_c2, px_c1, px_c0}, 32'hA1D4C3B2);
    @(negedge clk);
    out_ready = 1'b1;
    #1;
    @(negedge clk);
    #1 chk("R11 second pixel", {px_a, px_c2, px_c1, px_c0}, 32'h01040302);
    chk("R12 ready after pop", 32'(in_ready), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule